// File: doc/BRIEF.md
# Two-Wire Serial Slave with Busy Refusal

This block is a slave controller for a two-wire serial bus (I2C). It runs from a fast system clock and oversamples the bus clock and data lines. Each line passes through a two-flop synchronizer and a majority-free hold filter. From the filtered lines the block finds bus conditions and clock edges. It shifts in the address byte and any write bytes, and it shifts out read bytes. The ninth-bit acknowledge is driven through an open-drain style enable: when `sda_oe` is high, the pad pulls the data line low.

The block answers one fixed 7-bit address. A write transfer first loads a register pointer and then fills a small register file, with the pointer advancing after each byte. A read transfer returns bytes starting at the pointer. A `busy_i` input stands for a nonvolatile write in progress. While it is high, the slave refuses requests with a not-acknowledge, and it acknowledges normally again once `busy_i` falls.

Top module: `tws_busy_slave`

## Requirements
- R1: After reset, `sda_oe` is low, and it stays low until a START is followed by a matching address byte.
- R2: A START (SDA falling while SCL is high) restarts byte framing from any state, including in the middle of a byte and as a repeated START with no STOP before it. The next byte is then taken as an address.
- R3: A STOP (SDA rising while SCL is high) sends the slave to idle with SDA released. The slave ignores all clock pulses until the next START.
- R4: The address byte carries the address in bits 7..1, MSB first, and the direction in bit 0 (1 = read). The slave acknowledges only when bits 7..1 equal `DEV_ADDR` (default 7'h50) and `busy_i` is low. Otherwise it leaves SDA released for the rest of the transfer.
- R5: An acknowledge holds SDA low for the whole high phase of the ninth clock pulse. SDA is released during the low phase that follows.
- R6: In a write transfer, the first data byte sets the pointer from its low log2(DEPTH) bits. Each later byte is stored at the pointer, and the pointer then advances, wrapping modulo DEPTH. Every accepted data byte is acknowledged.
- R7: In a read transfer, bytes leave MSB first from the pointer, and the pointer advances after each byte. Data bits change only while SCL is low. After a master acknowledge (SDA low) the next byte follows. After a master not-acknowledge the slave stops driving SDA.
- R8: While `busy_i` is high, address bytes and write data bytes get a not-acknowledge, and a refused data byte is not stored. Acknowledging resumes once `busy_i` is low.
- R9: Transfers complete correctly at 400 kHz and at 100 kHz SCL with a 100 MHz system clock. The system clock must be at least 16 times the SCL rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | High while a nonvolatile write is in progress; requests are refused |
| sda_oe | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
Several properties are checked on every cycle by assertions:
- A START always restarts framing, and a STOP always idles the slave with SDA released.
- The enable never changes while the filtered clock is high, except at a bus condition.
- An acknowledge holds SDA low for the whole high phase of the ninth pulse.
- An address byte seen while busy is always refused.
- A write lands in the register file.
- The filtered lines only take a value the synchronizer has already shown.

Other behaviours can only be shown by the bench's scenarios, because each needs a whole sequence of bytes:
- pointer load, post-increment and wrap;
- bytes returned in the right order;
- a refused byte leaving the register unchanged;
- recovery after a mid-byte START or STOP;
- operation at both SCL rates.

// File: rtl/tws_pkg.sv
// Package: shared types for the two-wire slave.
// Assumes: nothing beyond IEEE 1800-2017.
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_ADDR,    // shifting address byte
        ST_ACK,     // slave acknowledging (ninth bit)
        ST_WRITE,   // shifting a write data byte
        ST_READ,    // driving a read data byte
        ST_MACK,    // waiting for master ack of read byte
        ST_IGNORE   // refused: released until START/STOP
    } tws_state_e;
endpackage

// File: rtl/tws_line_filter.sv
// Module: synchronizes one bus line and suppresses pulses shorter than
// FILT_LEN system clocks. Assumes the idle bus level is high.
module tws_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN) + 1;

    logic [1:0]    sync_q;
    logic [CW-1:0] hold_q;

    // Two-flop synchronizer into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Accept a new level only after it persists for FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            hold_q <= '0;
        end else if (sync_q[1] == line_o) begin
            hold_q <= '0;
        end else if (hold_q == CW'(FILT_LEN - 1)) begin
            line_o <= sync_q[1];
            hold_q <= '0;
        end else begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // R9: filtered output only moves to a level the synchronizer presented
    // R9
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> (line_o == $past(sync_q[1])));
endmodule

// File: rtl/tws_cond_detect.sv
// Module: finds SCL edges and START/STOP conditions on filtered lines.
// Assumes both inputs come through equal-latency filters.
module tws_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Remember previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges and bus conditions from old and new levels.
    always_comb begin
        scl_rise  = !scl_q && scl_f;
        scl_fall  = scl_q && !scl_f;
        start_det = scl_q && scl_f && sda_q && !sda_f;
        stop_det  = scl_q && scl_f && !sda_q && sda_f;
    end
endmodule

// File: rtl/tws_regfile.sv
// Module: small byte register file, one write port, one async read port.
// Assumes DEPTH is a power of two.
module tws_regfile #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    // Clear on reset, store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Read port follows the pointer.
    always_comb rdata_o = mem_q[raddr_i];

    // R6
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tws_busy_slave.sv
// Module: two-wire slave with register pointer, register file and busy
// refusal. Assumes clk >= 16x SCL; no clock stretching; DEPTH power of two.
module tws_busy_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         DEPTH    = 16,
    parameter int         FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic busy_i,
    output logic sda_oe
);
    import tws_pkg::*;
    localparam int PTR_W = $clog2(DEPTH);

    logic [1:0] raw_w, filt_w;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_w = {sda_i, scl_i};

    // One filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        tws_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_w[g]), .line_o(filt_w[g]));
    end
    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    tws_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    tws_state_e        state;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic              rw;
    logic              ptr_set;
    logic              mnack;
    logic [PTR_W-1:0]  ptr;
    logic              we;
    logic [7:0]        rdata;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt == 4'd8);

    // Store strobe: accepted write byte after the pointer is loaded.
    always_comb we = (state == ST_WRITE) && byte_done && ptr_set && !busy_i;

    tws_regfile #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr), .wdata_i(shreg),
        .raddr_i(ptr), .rdata_o(rdata));

    // Main framing state machine, advanced on filtered SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            ptr_set <= 1'b0;
            mnack   <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            ptr_set <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WRITE: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_f};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (busy_i) begin
                            state <= ST_IGNORE;
                        end else if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            if (!ptr_set) begin
                                ptr     <= shreg[PTR_W-1:0];
                                ptr_set <= 1'b1;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            shreg  <= rdata;
                            sda_oe <= !rdata[7];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_READ;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WRITE;
                        end
                    end
                end
                ST_READ: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_MACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= !shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mnack <= sda_f;
                    end else if (scl_fall) begin
                        if (mnack) begin
                            state <= ST_IGNORE;
                        end else begin
                            shreg  <= rdata;
                            sda_oe <= !rdata[7];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_READ;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR) && (cnt == 4'd0) && !sda_oe);

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe);

    // R7
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det))
            |-> !$past(scl_f));

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACK) && scl_f) |-> sda_oe);

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && byte_done && busy_i && !start_det && !stop_det)
            |=> (state == ST_IGNORE) && !sda_oe);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd8);
endmodule

// File: tb/tb_tws_busy_slave.sv
module tb_tws_busy_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    tws_busy_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .busy_i(busy), .sda_oe(sda_oe));

    typedef struct { string tag; logic [7:0] val; } item_t;
    item_t exp_q[$];
    logic [7:0] obs_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int hp = 125;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_item(input string tag, input logic [7:0] v);
        item_t it;
        it.tag = tag;
        it.val = v;
        exp_q.push_back(it);
    endtask

    // Monitor: pair each observed bus result with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(o === e.val, e.tag, o, e.val);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp);
        scl_m = 1'b0;
    endtask

    task automatic m_rstart();
        wt(hp / 2); sda_m = 1'b1; wt(hp / 2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp);
        scl_m = 1'b0;
    endtask

    task automatic m_stop();
        wt(hp / 2); sda_m = 1'b0; wt(hp / 2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b1; wt(hp);
    endtask

    task automatic m_wbit(input logic b);
        wt(hp / 2); sda_m = b; wt(hp / 2);
        scl_m = 1'b1; wt(hp);
        scl_m = 1'b0;
    endtask

    task automatic m_rbit(output logic b);
        wt(hp / 2); sda_m = 1'b1; wt(hp / 2);
        scl_m = 1'b1; wt(hp / 2);
        b = sda_bus; wt(hp / 2);
        scl_m = 1'b0;
    endtask

    // Sends a byte; pushes 1 for ACK, 0 for NACK to the observed queue.
    task automatic m_send(input logic [7:0] d);
        logic a;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(a);
        obs_q.push_back({7'd0, !a});
    endtask

    // Receives a byte and answers with nack (1) or ack (0).
    task automatic m_recv(input logic nack);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) m_rbit(d[i]);
        m_wbit(nack);
        obs_q.push_back(d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(20);
        chk(sda_oe === 1'b0, "R1 reset release", {7'd0, sda_oe}, 8'h00);

        // Write two bytes at pointer 3 (400 kHz).
        m_start();
        expect_item("R4 own address write ack", 8'h01); m_send(8'hA0);
        expect_item("R6 pointer byte ack", 8'h01);      m_send(8'h03);
        expect_item("R5 data ack", 8'h01);              m_send(8'hA5);
        expect_item("R6 second data ack", 8'h01);       m_send(8'h3C);
        m_stop();
        chk(sda_oe === 1'b0, "R3 released after stop", {7'd0, sda_oe}, 8'h00);

        // Read back through a repeated START.
        m_start();
        expect_item("R4 addr ack", 8'h01);  m_send(8'hA0);
        expect_item("R6 ptr ack", 8'h01);   m_send(8'h03);
        m_rstart();
        expect_item("R2 repeated start read ack", 8'h01); m_send(8'hA1);
        expect_item("R7 first read byte", 8'hA5);  m_recv(1'b0);
        expect_item("R7 second read byte", 8'h3C); m_recv(1'b1);
        wt(hp / 4);
        chk(sda_oe === 1'b0, "R7 release after master nack", {7'd0, sda_oe}, 8'h00);
        m_stop();

        // Foreign address: refused, following bytes ignored.
        m_start();
        expect_item("R4 foreign address nack", 8'h00); m_send(8'h42);
        expect_item("R3 ignored until stop", 8'h00);   m_send(8'h00);
        m_stop();

        // Busy refusal of address, then of a data byte.
        busy = 1'b1;
        m_start();
        expect_item("R8 busy address nack", 8'h00); m_send(8'hA0);
        m_stop();
        busy = 1'b0;
        m_start();
        expect_item("R8 resume ack", 8'h01); m_send(8'hA0);
        expect_item("R8 ptr ack", 8'h01);    m_send(8'h03);
        busy = 1'b1;
        expect_item("R8 busy data nack", 8'h00); m_send(8'h77);
        m_stop();
        busy = 1'b0;
        m_start();
        expect_item("R4 addr ack", 8'h01); m_send(8'hA0);
        expect_item("R6 ptr ack", 8'h01);  m_send(8'h03);
        m_rstart();
        expect_item("R4 read ack", 8'h01); m_send(8'hA1);
        expect_item("R8 refused byte not stored", 8'hA5); m_recv(1'b1);
        m_stop();

        // 100 kHz write crossing the pointer wrap.
        hp = 500;
        m_start();
        expect_item("R9 slow addr ack", 8'h01); m_send(8'hA0);
        expect_item("R9 slow ptr ack", 8'h01);  m_send(8'h0F);
        expect_item("R9 slow data ack", 8'h01); m_send(8'h11);
        expect_item("R6 wrap data ack", 8'h01); m_send(8'h22);
        m_stop();
        hp = 125;
        m_start();
        expect_item("R4 addr ack", 8'h01); m_send(8'hA0);
        expect_item("R6 ptr ack", 8'h01);  m_send(8'h0F);
        m_rstart();
        expect_item("R4 read ack", 8'h01); m_send(8'hA1);
        expect_item("R9 last register", 8'h11);   m_recv(1'b0);
        expect_item("R6 pointer wrapped", 8'h22); m_recv(1'b1);
        m_stop();

        // START in the middle of a byte restarts framing.
        m_start();
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
        m_rstart();
        expect_item("R2 mid-byte restart ack", 8'h01); m_send(8'hA0);
        expect_item("R6 ptr ack", 8'h01); m_send(8'h00);
        m_rstart();
        expect_item("R4 read ack", 8'h01); m_send(8'hA1);
        expect_item("R2 read after restart", 8'h22); m_recv(1'b1);
        m_stop();

        // STOP in the middle of a byte returns to idle.
        m_start();
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        m_stop();
        chk(sda_oe === 1'b0, "R3 mid-byte stop release", {7'd0, sda_oe}, 8'h00);
        m_start();
        expect_item("R3 fresh transfer ack", 8'h01); m_send(8'hA1);
        expect_item("R7 pointer continues", 8'h00);  m_recv(1'b1);
        m_stop();

        wt(20);
        while (obs_q.size() > 0) wt(1);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule